// File: doc/BRIEF.md
# Serial-Access March Memory Self-Test Controller

This block runs a March-style self-test over one or more RAMs of DEPTH words by WORD_W bits. Each RAM goes through a thin collar, so in test mode the controller needs one data bit per RAM instead of a word-wide comparator. While the test runs, each collar turns every write into a one-place shift of the addressed word. The bit from the controller, or from the previous RAM, enters at the most significant end. The least significant bit of the old word leaves as the serial output.

The collars form a daisy chain. Every RAM sees the same address and write strobe, and each collar's serial output feeds the next collar's serial input. The controller drives the head of the chain and checks the bit at its tail. One sweep of a word therefore takes NUM_RAM*WORD_W shift cycles, counted by a position counter, before the address counter moves on.

Outside a test, each collar passes functional address, write strobe and write data through unchanged. The RAM macros sit outside the block: they have a combinational read and are written on the rising clock edge.

Top module: `sbist_top`

## Requirements
- R1: After reset, `go` and `done` are 0 and the collars are in pass-through.
- R2: While no test runs, `mem_addr`, `mem_we` and `mem_wdata` equal `fn_addr`, `fn_we` and `fn_wdata`. `fn_rdata` always equals `mem_rdata`.
- R3: During a test, each RAM i writes `{si_i, rdata_i[WORD_W-1:1]}` back to the same address every cycle. Its serial output is `rdata_i[0]`.
- R4: During a test, all RAMs share one address and have `mem_we` high. RAM 0 takes its serial input from the controller, and RAM i+1 takes the serial output of RAM i.
- R5: The address is held for exactly NUM_RAM*WORD_W cycles and then steps by one.
- R6: Six sweeps run in this order:
  1. ascending, write 0, tail not checked;
  2. ascending, expect 0, write 1;
  3. ascending, expect 1, write 0;
  4. descending, expect 0, write 1;
  5. descending, expect 1, write 0;
  6. descending, expect 0, write 0.

  Ascending sweeps start at address 0 and descending sweeps start at DEPTH-1.
- R7: `done` rises exactly 6*DEPTH*NUM_RAM*WORD_W cycles after the clock edge that accepts `start`. It stays high until the next accepted `start`.
- R8: An accepted `start` sets `go` to 1. Any checked tail bit that differs from its expected value clears `go`, and `go` stays 0 until the next accepted `start`. A fault-free run ends with `go` = 1.
- R9: `start` is ignored while a test runs.
- R10: After a fault-free run, every word of every RAM reads back as 0 through the functional port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a test when no test is running |
| go | output | 1 | 1 while no checked bit has mismatched |
| done | output | 1 | Test finished |
| fn_addr | input | NUM_RAM*ADDR_W | Functional address, one slice per RAM |
| fn_we | input | NUM_RAM | Functional write strobe per RAM |
| fn_wdata | input | NUM_RAM*WORD_W | Functional write data per RAM |
| fn_rdata | output | NUM_RAM*WORD_W | Functional read data per RAM |
| mem_addr | output | NUM_RAM*ADDR_W | Address to each RAM macro |
| mem_we | output | NUM_RAM | Write strobe to each RAM macro |
| mem_wdata | output | NUM_RAM*WORD_W | Write data to each RAM macro |
| mem_rdata | input | NUM_RAM*WORD_W | Combinational read data from each RAM macro |

## Verification
A position counter that is off by one shows at once at the RAM ports: the address steps early or late within the same sweep, and the total run length no longer matches the exact cycle count. A wrong sweep attribute shows within one sweep. A wrong direction appears as the wrong start address. A wrong written bit leaves the chain with data that the next checked sweep reads as a mismatch, so `go` falls in a fault-free run. A broken chain link or shift shows on the write data of the next RAM a few cycles into the first writing sweep. Stuck cells placed in different RAMs, addresses and bit positions must each clear `go` before `done`.

// File: rtl/sbist_pkg.sv
package sbist_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } st_e;

  localparam int NUM_SWEEPS = 6;
  localparam int IDX_W      = 3;

  // Per-sweep attributes: direction, tail check enable, expected tail bit, bit shifted in
  typedef struct packed {
    logic asc;
    logic chk;
    logic exp_bit;
    logic wr_bit;
  } sweep_t;

  function automatic sweep_t sweep_attr(input logic [IDX_W-1:0] idx);
    sweep_t a;
    case (idx)
      3'd0:    a = sweep_t'(4'b1000);
      3'd1:    a = sweep_t'(4'b1101);
      3'd2:    a = sweep_t'(4'b1110);
      3'd3:    a = sweep_t'(4'b0101);
      3'd4:    a = sweep_t'(4'b0110);
      default: a = sweep_t'(4'b0100);
    endcase
    return a;
  endfunction

endpackage

// File: rtl/sbist_cnt.sv
module sbist_cnt #(
  parameter int DEPTH     = 8,
  parameter int CHAIN_LEN = 8,
  parameter int ADDR_W    = 3,
  parameter int POS_W     = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_asc,
  input  logic              step,
  input  logic              asc,
  output logic [ADDR_W-1:0] addr,
  output logic              pos_last,
  output logic              sweep_last
);

  localparam logic [ADDR_W-1:0] ADDR_TOP = ADDR_W'(DEPTH - 1);
  localparam logic [POS_W-1:0]  POS_TOP  = POS_W'(CHAIN_LEN - 1);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [POS_W-1:0]  pos_q, pos_d;

  assign pos_last   = (pos_q == POS_TOP);
  assign sweep_last = pos_last && (asc ? (addr_q == ADDR_TOP) : (addr_q == '0));
  assign addr       = addr_q;

  always_comb begin
    addr_d = addr_q;
    pos_d  = pos_q;
    if (load) begin
      pos_d  = '0;
      addr_d = load_asc ? '0 : ADDR_TOP;
    end else if (step) begin
      if (pos_last) begin
        pos_d  = '0;
        addr_d = asc ? addr_q + ADDR_W'(1) : addr_q - ADDR_W'(1);
      end else begin
        pos_d = pos_q + POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      pos_q  <= '0;
    end else if (load || step) begin
      addr_q <= addr_d;
      pos_q  <= pos_d;
    end
  end

endmodule

// File: rtl/sbist_seq.sv
module sbist_seq
  import sbist_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic sweep_last,
  input  logic tail_bit,
  output logic test_on,
  output logic load,
  output logic load_asc,
  output logic step,
  output logic asc,
  output logic wr_bit,
  output logic go,
  output logic done
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SWEEPS - 1);

  st_e              st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             go_q, go_d, done_q, done_d;
  sweep_t           cur, nxt;
  logic             start_ok, sweep_end;

  assign cur       = sweep_attr(idx_q);
  assign nxt       = sweep_attr(idx_q + IDX_W'(1));
  assign start_ok  = start && (st_q != ST_RUN);
  assign sweep_end = (st_q == ST_RUN) && sweep_last;

  assign test_on  = (st_q == ST_RUN);
  assign step     = (st_q == ST_RUN);
  assign load     = start_ok || (sweep_end && (idx_q != LAST_IDX));
  assign load_asc = start_ok ? 1'b1 : nxt.asc;
  assign asc      = cur.asc;
  assign wr_bit   = cur.wr_bit;
  assign go       = go_q;
  assign done     = done_q;

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    go_d   = go_q;
    done_d = done_q;
    if (start_ok) begin
      st_d   = ST_RUN;
      idx_d  = '0;
      go_d   = 1'b1;
      done_d = 1'b0;
    end else if (st_q == ST_RUN) begin
      if (cur.chk && (tail_bit != cur.exp_bit)) go_d = 1'b0;
      if (sweep_end) begin
        if (idx_q == LAST_IDX) begin
          st_d   = ST_FIN;
          done_d = 1'b1;
        end else begin
          idx_d = idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      go_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      go_q   <= go_d;
      done_q <= done_d;
    end
  end

endmodule

// File: rtl/sbist_collar.sv
module sbist_collar #(
  parameter int WORD_W = 4,
  parameter int ADDR_W = 3
) (
  input  logic              test_on,
  input  logic [ADDR_W-1:0] t_addr,
  input  logic              si,
  input  logic [ADDR_W-1:0] fn_addr,
  input  logic              fn_we,
  input  logic [WORD_W-1:0] fn_wdata,
  input  logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_wdata,
  output logic              so
);

  logic [WORD_W-1:0] shifted;

  generate
    if (WORD_W > 1) begin : g_wide
      assign shifted = {si, rdata[WORD_W-1:1]};
    end else begin : g_one
      assign shifted = si;
    end
  endgenerate

  assign so        = rdata[0];
  assign mem_addr  = test_on ? t_addr  : fn_addr;
  assign mem_we    = test_on ? 1'b1    : fn_we;
  assign mem_wdata = test_on ? shifted : fn_wdata;

endmodule

// File: rtl/sbist_top.sv
module sbist_top #(
  parameter  int NUM_RAM   = 2,
  parameter  int WORD_W    = 4,
  parameter  int DEPTH     = 8,
  localparam int ADDR_W    = $clog2(DEPTH),
  localparam int CHAIN_LEN = NUM_RAM * WORD_W,
  localparam int POS_W     = $clog2(CHAIN_LEN)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  output logic                        go,
  output logic                        done,
  input  logic [NUM_RAM*ADDR_W-1:0]   fn_addr,
  input  logic [NUM_RAM-1:0]          fn_we,
  input  logic [NUM_RAM*WORD_W-1:0]   fn_wdata,
  output logic [NUM_RAM*WORD_W-1:0]   fn_rdata,
  output logic [NUM_RAM*ADDR_W-1:0]   mem_addr,
  output logic [NUM_RAM-1:0]          mem_we,
  output logic [NUM_RAM*WORD_W-1:0]   mem_wdata,
  input  logic [NUM_RAM*WORD_W-1:0]   mem_rdata
);

  logic              test_on, ld, ld_asc, stp, asc, wr_bit;
  logic              pos_last, sweep_last;
  logic [ADDR_W-1:0] t_addr;
  logic [NUM_RAM:0]  chain;

  assign chain[0] = wr_bit;
  assign fn_rdata = mem_rdata;

  sbist_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .sweep_last(sweep_last),
    .tail_bit  (chain[NUM_RAM]),
    .test_on   (test_on),
    .load      (ld),
    .load_asc  (ld_asc),
    .step      (stp),
    .asc       (asc),
    .wr_bit    (wr_bit),
    .go        (go),
    .done      (done)
  );

  sbist_cnt #(
    .DEPTH    (DEPTH),
    .CHAIN_LEN(CHAIN_LEN),
    .ADDR_W   (ADDR_W),
    .POS_W    (POS_W)
  ) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ld),
    .load_asc  (ld_asc),
    .step      (stp),
    .asc       (asc),
    .addr      (t_addr),
    .pos_last  (pos_last),
    .sweep_last(sweep_last)
  );

  generate
    for (genvar g = 0; g < NUM_RAM; g++) begin : g_ram
      sbist_collar #(
        .WORD_W(WORD_W),
        .ADDR_W(ADDR_W)
      ) u_collar (
        .test_on  (test_on),
        .t_addr   (t_addr),
        .si       (chain[g]),
        .fn_addr  (fn_addr[g*ADDR_W +: ADDR_W]),
        .fn_we    (fn_we[g]),
        .fn_wdata (fn_wdata[g*WORD_W +: WORD_W]),
        .rdata    (mem_rdata[g*WORD_W +: WORD_W]),
        .mem_addr (mem_addr[g*ADDR_W +: ADDR_W]),
        .mem_we   (mem_we[g]),
        .mem_wdata(mem_wdata[g*WORD_W +: WORD_W]),
        .so       (chain[g+1])
      );
    end
  endgenerate

endmodule

// File: rtl/sbist_chk.sv
module sbist_chk #(
  parameter int NUM_RAM = 2,
  parameter int WORD_W  = 4,
  parameter int ADDR_W  = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      start,
  input logic                      go,
  input logic                      done,
  input logic                      test_on,
  input logic                      pos_last,
  input logic [ADDR_W-1:0]         t_addr,
  input logic [NUM_RAM-1:0]        mem_we,
  input logic [NUM_RAM*WORD_W-1:0] mem_wdata,
  input logic [NUM_RAM*WORD_W-1:0] mem_rdata
);

  // R8
  go_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(go) |-> $past(start));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done);

  // R7
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(test_on));

  // R9
  run_not_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_on |-> !done);

  // R5
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_on && $past(test_on) && !$past(pos_last) |-> $stable(t_addr));

  // R4
  test_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    test_on |-> (&mem_we));

  generate
    for (genvar i = 0; i < NUM_RAM; i++) begin : g_shift
      if (WORD_W > 1) begin : g_w
        // R3
        shift_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
          test_on |-> mem_wdata[i*WORD_W +: WORD_W-1] == mem_rdata[i*WORD_W+1 +: WORD_W-1]);
      end
      if (i > 0) begin : g_link
        // R4
        chain_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
          test_on |-> mem_wdata[i*WORD_W + WORD_W-1] == mem_rdata[(i-1)*WORD_W]);
      end
    end
  endgenerate

endmodule

bind sbist_top sbist_chk #(
  .NUM_RAM(NUM_RAM),
  .WORD_W (WORD_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .go       (go),
  .done     (done),
  .test_on  (test_on),
  .pos_last (pos_last),
  .t_addr   (t_addr),
  .mem_we   (mem_we),
  .mem_wdata(mem_wdata),
  .mem_rdata(mem_rdata)
);

// File: tb/sbist_top_bench.sv
module sbist_top_bench;

  localparam int NR  = 2;
  localparam int WW  = 4;
  localparam int DP  = 8;
  localparam int AW  = 3;
  localparam int L   = NR * WW;
  localparam int RUN = 6 * DP * L;

  // {fault_en, ram, addr[2:0], bit[1:0], stuck_val, expected_go}
  localparam int NV = 6;
  localparam logic [8:0] VEC [NV] = '{
    9'b0_0_000_00_0_1,
    9'b1_0_000_00_1_0,
    9'b1_1_111_11_0_0,
    9'b1_0_101_10_0_0,
    9'b1_1_010_01_1_0,
    9'b0_0_000_00_0_1
  };

  logic clk, rst_n, start, go, done;
  logic [NR*AW-1:0] fn_addr, mem_addr;
  logic [NR-1:0]    fn_we, mem_we;
  logic [NR*WW-1:0] fn_wdata, fn_rdata, mem_wdata, mem_rdata;

  logic       f_en, f_val;
  logic       f_ram;
  logic [2:0] f_addr;
  logic [1:0] f_bit;

  logic [WW-1:0] ram [NR][DP];

  int tests = 0;
  int fails = 0;
  int m     = 0;

  sbist_top u_sbist_top (
    .clk(clk), .rst_n(rst_n), .start(start), .go(go), .done(done),
    .fn_addr(fn_addr), .fn_we(fn_we), .fn_wdata(fn_wdata), .fn_rdata(fn_rdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      logic [WW-1:0] w;
      w = ram[i][mem_addr[i*AW +: AW]];
      if (f_en && (int'(f_ram) == i) && (mem_addr[i*AW +: AW] == f_addr)) w[f_bit] = f_val;
      mem_rdata[i*WW +: WW] = w;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NR; i++)
      if (mem_we[i]) ram[i][mem_addr[i*AW +: AW]] <= mem_wdata[i*WW +: WW];
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic adv_to(input int target);
    while (m < target) begin
      @(negedge clk);
      m++;
    end
  endtask

  task automatic launch();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    m = 0;
  endtask

  task automatic finish_run(output int cyc);
    while (!done && m < 2000) begin
      @(negedge clk);
      m++;
    end
    cyc = m;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL R7 watchdog actual=%0h expected=%0h", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    rst_n = 1'b0; start = 1'b0;
    fn_addr = '0; fn_we = '0; fn_wdata = '0;
    f_en = 1'b0; f_val = 1'b0; f_ram = 1'b0; f_addr = '0; f_bit = '0;
    repeat (3) @(negedge clk);
    chk(go == 1'b0 && done == 1'b0, "R1 reset go/done", {go, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(go == 1'b0 && done == 1'b0, "R1 after release", {go, done}, 0);

    // R2 pass-through while idle
    fn_we = 2'b11; fn_addr = {3'd5, 3'd2}; fn_wdata = 8'h3A;
    #1;
    chk(mem_we == 2'b11 && mem_addr == {3'd5, 3'd2} && mem_wdata == 8'h3A,
        "R2 bypass", {mem_we, mem_addr, mem_wdata}, {2'b11, 3'd5, 3'd2, 8'h3A});
    for (int a = 0; a < DP; a++) begin
      @(negedge clk);
      fn_addr = {3'(a), 3'(a)}; fn_wdata = 8'h5A; fn_we = 2'b11;
    end
    @(negedge clk);
    fn_we = 2'b00; fn_addr = {3'd6, 3'd6};
    #1;
    chk(fn_rdata == 8'h5A, "R2 functional read", fn_rdata, 8'h5A);

    // Directed fault-free run with cycle-exact samples
    launch();
    chk(mem_we == 2'b11 && mem_addr == 6'd0, "R4 common addr and strobe", {mem_we, mem_addr}, {2'b11, 6'd0});
    chk(go == 1'b1 && done == 1'b0, "R8 go set on start", {go, done}, 2'b10);
    adv_to(DP * L);
    chk(mem_wdata[3:0] == 4'h8, "R3 first shift 1000", mem_wdata[3:0], 4'h8);
    adv_to(DP * L + 1);
    chk(mem_wdata[3:0] == 4'hC, "R3 second shift 1100", mem_wdata[3:0], 4'hC);
    adv_to(DP * L + 3);
    chk(mem_wdata[3:0] == 4'hF, "R3 fourth shift 1111", mem_wdata[3:0], 4'hF);
    adv_to(DP * L + 4);
    chk(mem_wdata == 8'h8F, "R4 chain feeds second RAM", mem_wdata, 8'h8F);
    adv_to(DP * L + L - 1);
    chk(mem_addr == 6'd0, "R5 address held", mem_addr, 0);
    adv_to(DP * L + L);
    chk(mem_addr == {3'd1, 3'd1}, "R5 address steps", mem_addr, {3'd1, 3'd1});
    adv_to(100);
    start = 1'b1;
    adv_to(101);
    start = 1'b0;
    adv_to(3 * DP * L);
    chk(mem_addr == {3'd7, 3'd7} && mem_wdata[3:0] == 4'h8, "R6 descending sweep start",
        {mem_addr, mem_wdata[3:0]}, {3'd7, 3'd7, 4'h8});
    adv_to(5 * DP * L);
    chk(mem_addr == {3'd7, 3'd7} && mem_wdata[3:0] == 4'h0, "R6 final sweep start",
        {mem_addr, mem_wdata[3:0]}, {3'd7, 3'd7, 4'h0});
    finish_run(cyc);
    chk(cyc == RUN, "R9 R7 run length with ignored start", cyc, RUN);
    chk(go == 1'b1, "R8 fault-free go", go, 1);
    repeat (5) @(negedge clk);
    chk(done == 1'b1, "R7 done holds", done, 1);
    chk(mem_we == fn_we, "R2 bypass after test", mem_we, fn_we);
    for (int a = 0; a < DP; a++) begin
      fn_addr = {3'(a), 3'(a)};
      #1;
      chk(fn_rdata == 8'h00, "R10 memory cleared", fn_rdata, 0);
    end

    // Vector table: fault scenarios
    for (int v = 0; v < NV; v++) begin
      f_en = VEC[v][8]; f_ram = VEC[v][7]; f_addr = VEC[v][6:4];
      f_bit = VEC[v][3:2]; f_val = VEC[v][1];
      launch();
      chk(done == 1'b0 && go == 1'b1, "R8 restart clears done", {go, done}, 2'b10);
      finish_run(cyc);
      chk(cyc == RUN, "R7 run length", cyc, RUN);
      chk(go == VEC[v][0], "R8 go result", go, VEC[v][0]);
    end
    f_en = 1'b0;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule